// File: doc/BRIEF.md
# UART Receive Character Queue with Fill-Level Interrupt

This block sits behind the serial deserializer of a UART receiver and buffers its completed characters. Each time the deserializer reports a finished character (data word plus parity-error and framing-error flags, raised when the stop bit is seen), the block moves the character into a small first-in first-out queue. A one-entry staging register stands in front of the queue, so up to one more character than the queue depth can be held at once.

The reader sees the oldest entry on the data and flag outputs and removes it with a one-cycle pop strobe. A two-bit select input chooses when a one-cycle interrupt pulse is raised: on every transfer into the queue, on the transfer that brings the queue to one below full, or on the transfer that fills it. When a character completes while the queue is full, the block raises a sticky overrun flag and freezes. No further character is accepted, and everything already held stays intact until the flag is cleared.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the queue is empty: `data_avail`, `overrun` and `rx_irq` are 0 and `rx_data`, `rx_perr` and `rx_ferr` are 0. A reset also discards any stored entries.
- R2: `data_avail` is 1 exactly when the queue holds at least one entry.
- R3: The outputs show the oldest entry: its data word, parity-error flag and framing-error flag. A `rd_pop` pulse removes that entry, and the next entry is shown from the following cycle. Entries leave in the order they arrived.
- R4: With `irq_sel` equal to 2'b00 or 2'b01, `rx_irq` pulses for one cycle after every transfer into the queue.
- R5: A `rd_pop` pulse while the queue is empty leaves the outputs unchanged and moves no pointer. A later character is the next one read.
- R6: With `irq_sel` equal to 2'b10, `rx_irq` pulses only after a transfer that leaves DEPTH-1 entries (3 by default) in the queue.
- R7: With `irq_sel` equal to 2'b11, `rx_irq` pulses only after a transfer that leaves the queue full (DEPTH entries).
- R8: A character that completes while the queue is full, with no pop in the same cycle, is kept in the staging register and sets `overrun`. `overrun` then stays 1 until cleared.
- R9: While `overrun` is 1, completed characters are dropped and the staged character is not transferred, even if a pop frees a slot. The staged character and all queued entries stay valid.
- R10: `ovr_clr` clears `overrun` at the next edge. In the cycle after that, the staged character moves into the queue if a slot is free.
- R11: A pop and a transfer in the same cycle both take effect, leaving the entry count unchanged. A character completing into a full queue together with a pop therefore raises no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | Deserializer reports a completed character (stop bit seen) |
| char_data | input | DATA_W | Data word of the completed character |
| char_perr | input | 1 | Parity error of the completed character |
| char_ferr | input | 1 | Framing error of the completed character |
| irq_sel | input | 2 | Interrupt threshold select |
| rd_pop | input | 1 | Remove the oldest entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rx_data | output | DATA_W | Data word of the oldest entry |
| rx_perr | output | 1 | Parity-error flag of the oldest entry |
| rx_ferr | output | 1 | Framing-error flag of the oldest entry |
| data_avail | output | 1 | Queue holds at least one entry |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench fills the queue to full and then sends one more character and then another. A design that overwrote the staged character, or let the later character in, would show a wrong or extra word when the queue is drained after `ovr_clr`. It pops an empty queue and then sends a fresh character. A design that moved its read pointer anyway would present stale data in place of the new word. It issues a pop and a completion together while the queue is full, where a wrong design would flag overrun or lose an entry. It walks each threshold code through a fill from empty, where a design with an off-by-one count would pulse on the wrong character.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    parameter int unsigned RXQ_DATA_W = 9;

    typedef struct packed {
        logic                  perr;
        logic                  ferr;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        IRQ_EACH_A = 2'b00,
        IRQ_EACH_B = 2'b01,
        IRQ_NEARLY = 2'b10,
        IRQ_FULL   = 2'b11
    } rxq_irq_mode_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rxq_entry_t       push_ent,
    input  logic             pop,
    output rxq_entry_t       head_ent,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    rxq_entry_t mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = st_q.wr + PTR_W'(1);
        if (pop)  st_d.rd = st_q.rd + PTR_W'(1);
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= push_ent;
    end

    assign head_ent = mem_q[st_q.rd];
    assign count    = st_q.cnt;
endmodule

// File: rtl/rxq_irq_sel.sv
module rxq_irq_sel
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             push,
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] new_cnt,
    output logic             fire
);
    localparam logic [CNT_W-1:0] NEAR_LVL = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    always_comb begin
        unique case (rxq_irq_mode_e'(sel))
            IRQ_NEARLY: fire = push && (new_cnt == NEAR_LVL);
            IRQ_FULL:   fire = push && (new_cnt == FULL_LVL);
            default:    fire = push;
        endcase
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned DATA_W = RXQ_DATA_W,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic [1:0]        irq_sel,
    input  logic              rd_pop,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              data_avail,
    output logic              rx_irq,
    output logic              overrun
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    typedef struct packed {
        rxq_entry_t stage;
        logic       stage_vld;
        logic       ovr;
        logic       irq;
        rxq_entry_t shown;
    } top_state_t;

    top_state_t st_d, st_q;

    rxq_entry_t       in_ent, head_ent, push_ent, cur_ent;
    logic             push, pop_ok, room, take, fire;
    logic [CNT_W-1:0] cnt_q, new_cnt;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop_ok),
        .head_ent (head_ent),
        .count    (cnt_q)
    );

    rxq_irq_sel #(.DEPTH(DEPTH)) u_irq (
        .push    (push),
        .sel     (irq_sel),
        .new_cnt (new_cnt),
        .fire    (fire)
    );

    always_comb begin
        in_ent.perr = char_perr;
        in_ent.ferr = char_ferr;
        in_ent.data = char_data;

        pop_ok   = rd_pop && (cnt_q != '0);
        room     = (cnt_q < FULL_LVL) || pop_ok;
        take     = !st_q.ovr && room;
        push     = 1'b0;
        push_ent = st_q.stage;
        st_d     = st_q;

        if (ovr_clr) st_d.ovr = 1'b0;

        if (st_q.stage_vld) begin
            if (take) begin
                push           = 1'b1;
                st_d.stage_vld = 1'b0;
            end
            if (char_valid && !st_q.ovr) begin
                if (take) begin
                    st_d.stage     = in_ent;
                    st_d.stage_vld = 1'b1;
                end else begin
                    st_d.ovr = 1'b1;
                end
            end
        end else if (char_valid && !st_q.ovr) begin
            if (take) begin
                push     = 1'b1;
                push_ent = in_ent;
            end else begin
                st_d.stage     = in_ent;
                st_d.stage_vld = 1'b1;
                st_d.ovr       = 1'b1;
            end
        end

        new_cnt    = cnt_q + CNT_W'(push) - CNT_W'(pop_ok);
        st_d.irq   = fire;
        cur_ent    = (cnt_q != '0) ? head_ent : st_q.shown;
        st_d.shown = cur_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data    = cur_ent.data;
    assign rx_perr    = cur_ent.perr;
    assign rx_ferr    = cur_ent.ferr;
    assign data_avail = (cnt_q != '0);
    assign rx_irq     = st_q.irq;
    assign overrun    = st_q.ovr;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid,
    input logic              ovr_clr,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_perr,
    input logic              rx_ferr,
    input logic              data_avail,
    input logic              rx_irq,
    input logic              overrun
);
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun);

    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(char_valid));

    assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && ovr_clr |=> !overrun);

    assert_irq_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> data_avail);

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !data_avail && !char_valid && !overrun && !$past(overrun)
        |=> !data_avail && $stable(rx_data) && $stable(rx_perr) && $stable(rx_ferr));
endmodule

bind uart_rx_fifo rxq_checker #(.DATA_W(DATA_W)) u_rxq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .ovr_clr    (ovr_clr),
    .rx_data    (rx_data),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr),
    .data_avail (data_avail),
    .rx_irq     (rx_irq),
    .overrun    (overrun)
);

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          char_valid = 1'b0;
    logic [DW-1:0] char_data = '0;
    logic          char_perr = 1'b0;
    logic          char_ferr = 1'b0;
    logic [1:0]    irq_sel = 2'b00;
    logic          rd_pop = 1'b0;
    logic          ovr_clr = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_perr, rx_ferr, data_avail, rx_irq, overrun;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [DW+1:0] exp_q [$];

    uart_rx_fifo i_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_perr(char_perr), .char_ferr(char_ferr), .irq_sel(irq_sel),
        .rd_pop(rd_pop), .ovr_clr(ovr_clr), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .data_avail(data_avail), .rx_irq(rx_irq), .overrun(overrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // driver: one completed character, scoreboard entry queued if it will be kept
    task automatic send(input logic [DW-1:0] d, input logic p, input logic f, input bit kept);
        char_valid = 1'b1; char_data = d; char_perr = p; char_ferr = f;
        @(negedge clk);
        char_valid = 1'b0;
        if (kept) exp_q.push_back({p, f, d});
    endtask

    // monitor: compare the presented head with the scoreboard, then pop it
    task automatic read_one(input string req);
        logic [DW+1:0] e;
        e = exp_q.pop_front();
        check(data_avail == 1'b1, req, data_avail, 1);
        check({rx_perr, rx_ferr, rx_data} == e, req, {rx_perr, rx_ferr, rx_data}, e);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(data_avail == 0 && overrun == 0 && rx_irq == 0, "R1", {data_avail, overrun, rx_irq}, 0);
        check({rx_perr, rx_ferr, rx_data} == 0, "R1", {rx_perr, rx_ferr, rx_data}, 0);

        // R4 every-transfer mode, R2 availability, R3 flags
        irq_sel = 2'b00;
        send(9'h1A5, 1'b1, 1'b0, 1'b1);
        check(rx_irq == 1, "R4", rx_irq, 1);
        check(data_avail == 1, "R2", data_avail, 1);
        irq_sel = 2'b01;
        send(9'h03C, 1'b0, 1'b1, 1'b1);
        check(rx_irq == 1, "R4", rx_irq, 1);
        read_one("R3");
        read_one("R3");
        check(data_avail == 0, "R2", data_avail, 0);

        // R5 pop of an empty queue
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        check(rx_data == 9'h03C && rx_ferr == 1, "R5", rx_data, 9'h03C);
        check(data_avail == 0, "R5", data_avail, 0);
        send(9'h0F0, 1'b0, 1'b0, 1'b1);
        read_one("R5");

        // R6 three-entry threshold
        irq_sel = 2'b10;
        for (int i = 0; i < 4; i++) begin
            send(DW'(9'h100 + i), i[0], i[1], 1'b1);
            check(rx_irq == (i == 2), "R6", rx_irq, (i == 2));
        end
        for (int i = 0; i < 4; i++) read_one("R3");

        // R7 full threshold
        irq_sel = 2'b11;
        for (int i = 0; i < 4; i++) begin
            send(DW'(9'h040 + i), 1'b0, i[0], 1'b1);
            check(rx_irq == (i == 3), "R7", rx_irq, (i == 3));
        end

        // R8 overrun on a fifth character, R9 freeze
        send(9'h1EE, 1'b1, 1'b1, 1'b1);
        check(overrun == 1, "R8", overrun, 1);
        check(rx_irq == 0, "R8", rx_irq, 0);
        send(9'h0BB, 1'b0, 1'b0, 1'b0);
        check(overrun == 1, "R9", overrun, 1);
        for (int i = 0; i < 4; i++) read_one("R9");
        @(negedge clk);
        check(data_avail == 0, "R9", data_avail, 0);
        check(overrun == 1, "R8", overrun, 1);

        // R10 clear, then staged character transfers
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(overrun == 0, "R10", overrun, 0);
        @(negedge clk);
        read_one("R10");
        check(data_avail == 0, "R9", data_avail, 0);

        // R11 pop and transfer together on a full queue
        irq_sel = 2'b11;
        for (int i = 0; i < 4; i++) send(DW'(9'h080 + i), 1'b0, 1'b0, 1'b1);
        begin
            logic [DW+1:0] e;
            e = exp_q.pop_front();
            check({rx_perr, rx_ferr, rx_data} == e, "R11", rx_data, e);
            rd_pop = 1'b1;
            char_valid = 1'b1; char_data = 9'h155; char_perr = 1'b1; char_ferr = 1'b0;
            @(negedge clk);
            rd_pop = 1'b0; char_valid = 1'b0;
            exp_q.push_back({1'b1, 1'b0, 9'h155});
        end
        check(overrun == 0, "R11", overrun, 0);
        check(rx_irq == 1, "R7", rx_irq, 1);
        for (int i = 0; i < 4; i++) read_one("R11");
        check(data_avail == 0, "R11", data_avail, 0);

        // R1 reset discards stored entries
        send(9'h011, 1'b0, 1'b0, 1'b0);
        send(9'h022, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(data_avail == 0 && overrun == 0, "R1", {data_avail, overrun}, 0);
        check(rx_data == 0, "R1", rx_data, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule